// File: doc/BRIEF.md
# UART Baud Tick Generator with High-Speed Divisor Codes

This block produces the single-cycle sampling enable that a UART's transmit and receive shifters use, at sixteen times the selected baud rate. Software loads a 16-bit divisor one byte at a time. Each divisor step stands for one period of a 1.8432 MHz reference. The block itself runs from a clock four times faster (7.3728 MHz), so a normal divisor D gives one tick every 4·D clock cycles. A divisor of 1 therefore gives a 1.8432 MHz tick rate, which is 115200 baud.

A high-speed configuration bit gives two divisor codes a second meaning. With the bit set, code 0x8002 gives 230400 baud and code 0x8001 gives 460800 baud. Without this, those codes would give very slow rates. Both fast rates are above what the reference alone can reach. They are made from the faster block clock: 0x8002 gives a tick every 2 cycles, and 0x8001 gives a tick on every cycle. For all other divisors the high-speed bit has no effect.

Top module: `uart_baud_gen`

## Requirements
- R1: With a normal divisor D, `tick` is high for exactly one `clk` cycle in every 4·D cycles. Examples: D=1 gives a period of 4, D=12 (9600 baud) gives 48, D=96 gives 384, D=857 (134.5 baud) gives 3428, D=1047 (110 baud) gives 4188, and D=2304 (50 baud) gives 9216.
- R2: The divisor is loaded by byte writes. `wr_byte` goes to bits 7:0 when `div_byte_we[0]` is high and to bits 15:8 when `div_byte_we[1]` is high. A write changes only its own byte.
- R3: Any divisor byte write restarts the count. If the edge that takes the write is edge E and the resulting period is P, the next tick is high in the cycle after edge E+P−1. Ticks then follow every P cycles. Any count already in progress is dropped.
- R4: While the divisor is 0, `tick` stays low.
- R5: With `hs_mode` set and divisor 0x8002, the tick period is 2 cycles (230400 baud).
- R6: With `hs_mode` set and divisor 0x8001, `tick` is high on every cycle (460800 baud).
- R7: With `hs_mode` clear, divisors 0x8001 and 0x8002 are normal divisors with periods of 131076 and 131080 cycles. No tick appears within the first thousand cycles after they are loaded.
- R8: For every divisor other than 0x8001 and 0x8002, `hs_mode` has no effect. Setting or clearing it changes neither the tick period nor the phase of the ticks.
- R9: While `rst_n` is low, and after reset until a divisor is written, `tick` is low. The divisor and the high-speed bit both reset to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, four times the 1.8432 MHz reference |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| div_byte_we | input | 2 | Per-byte divisor write enables, bit 0 for the low byte and bit 1 for the high byte |
| wr_byte | input | 8 | Data for the divisor byte write |
| hs_mode | input | 1 | High-speed configuration bit, registered inside the block |
| tick | output | 1 | Single-cycle 16x baud enable |

## Verification
The corner cases are the two high-speed codes. They are tested with the bit set, with the bit clear, and with the bit turned on while a long count is already running. A design that decoded the codes without checking the bit would tick fast when it should stay silent. A counter that failed to wrap when its period shrank would run on to its overflow and miss the 2-cycle cadence. The bench writes a single byte mid-count and expects the count to restart. A design that carried on from the old count would give an early tick. A design that cleared the other byte on a write would show the wrong period. The bench toggles the high-speed bit under a normal divisor and expects the tick phase to stay the same. It also clears the divisor to zero and expects no ticks, which catches an underflowed period that would otherwise give a runaway tick.

// File: rtl/uart_baud_pkg.sv
package uart_baud_pkg;

  // Rate selection decoded from divisor and high-speed bit
  typedef enum logic [1:0] {
    RATE_OFF = 2'd0,
    RATE_STD = 2'd1,
    RATE_X2  = 2'd2,
    RATE_X4  = 2'd3
  } rate_sel_e;

endpackage

// File: rtl/baud_div_regs.sv
// Divisor byte registers and registered high-speed bit.
module baud_div_regs #(
  parameter int unsigned DIV_W = 16,
  localparam int unsigned NB = DIV_W / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NB-1:0]    byte_we,
  input  logic [7:0]       wr_byte,
  input  logic             hs_in,
  output logic [DIV_W-1:0] divisor,
  output logic             hs_q,
  output logic             reload
);

  logic hs_d;

  for (genvar g = 0; g < NB; g++) begin : g_byte
    logic [7:0] byte_q;
    logic [7:0] byte_d;

    always_comb begin
      byte_d = byte_q;
      if (byte_we[g]) begin
        byte_d = wr_byte;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= '0;
      end else begin
        byte_q <= byte_d;
      end
    end

    assign divisor[g*8 +: 8] = byte_q;
  end

  always_comb begin
    hs_d   = hs_in;
    reload = |byte_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q <= 1'b0;
    end else begin
      hs_q <= hs_d;
    end
  end

endmodule

// File: rtl/baud_rate_decode.sv
// Maps divisor and high-speed bit to a tick period in block clocks.
module baud_rate_decode
  import uart_baud_pkg::*;
#(
  parameter int unsigned DIV_W     = 16,
  parameter int unsigned REF_RATIO = 4,
  parameter int unsigned X2_CODE   = 32770,
  parameter int unsigned X4_CODE   = 32769,
  localparam int unsigned CNT_W    = DIV_W + $clog2(REF_RATIO)
) (
  input  logic [DIV_W-1:0] divisor,
  input  logic             hs,
  output rate_sel_e        sel,
  output logic [CNT_W-1:0] period
);

  localparam logic [DIV_W-1:0] X2_DIV = DIV_W'(X2_CODE);
  localparam logic [DIV_W-1:0] X4_DIV = DIV_W'(X4_CODE);
  localparam logic [CNT_W-1:0] X2_PER = CNT_W'(REF_RATIO / 2);
  localparam logic [CNT_W-1:0] X4_PER = CNT_W'(REF_RATIO / 4);
  localparam logic [CNT_W-1:0] RATIO  = CNT_W'(REF_RATIO);

  always_comb begin
    if (divisor == '0) begin
      sel = RATE_OFF;
    end else if (hs && (divisor == X4_DIV)) begin
      sel = RATE_X4;
    end else if (hs && (divisor == X2_DIV)) begin
      sel = RATE_X2;
    end else begin
      sel = RATE_STD;
    end
  end

  always_comb begin
    unique case (sel)
      RATE_OFF: period = '0;
      RATE_X2:  period = X2_PER;
      RATE_X4:  period = X4_PER;
      default:  period = CNT_W'(divisor) * RATIO;
    endcase
  end

endmodule

// File: rtl/baud_tick_gen.sv
// Free-running period counter producing a one-cycle tick.
module baud_tick_gen #(
  parameter int unsigned CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             tick
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] last;
  logic             run;

  always_comb begin
    run  = (period != '0);
    last = period - CNT_W'(1);
    tick = run && (cnt_q == last);
    if (reload || !run) begin
      cnt_d = '0;
    end else if (cnt_q >= last) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/uart_baud_gen.sv
// Top: 16x baud tick generator with high-speed divisor codes.
module uart_baud_gen
  import uart_baud_pkg::*;
#(
  parameter int unsigned DIV_W     = 16,
  parameter int unsigned REF_RATIO = 4,
  parameter int unsigned X2_CODE   = 32770,
  parameter int unsigned X4_CODE   = 32769
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DIV_W/8-1:0]   div_byte_we,
  input  logic [7:0]           wr_byte,
  input  logic                 hs_mode,
  output logic                 tick
);

  localparam int unsigned CNT_W = DIV_W + $clog2(REF_RATIO);

  logic [1:0]       rst_sync_q;
  logic [1:0]       rst_sync_d;
  logic             rst_n_int;
  logic [DIV_W-1:0] div_q;
  logic             hs_q;
  logic             reload;
  rate_sel_e        sel;
  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] cnt;

  // asynchronous assert, synchronous release
  always_comb begin
    rst_sync_d = {rst_sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= rst_sync_d;
    end
  end

  assign rst_n_int = rst_sync_q[1];

  baud_div_regs #(
    .DIV_W (DIV_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .byte_we (div_byte_we),
    .wr_byte (wr_byte),
    .hs_in   (hs_mode),
    .divisor (div_q),
    .hs_q    (hs_q),
    .reload  (reload)
  );

  baud_rate_decode #(
    .DIV_W     (DIV_W),
    .REF_RATIO (REF_RATIO),
    .X2_CODE   (X2_CODE),
    .X4_CODE   (X4_CODE)
  ) u_decode (
    .divisor (div_q),
    .hs      (hs_q),
    .sel     (sel),
    .period  (period)
  );

  baud_tick_gen #(
    .CNT_W (CNT_W)
  ) u_count (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .reload (reload),
    .period (period),
    .cnt    (cnt),
    .tick   (tick)
  );

endmodule

// File: rtl/uart_baud_gen_chk.sv
// Property checker attached to the baud generator.
module uart_baud_gen_chk
  import uart_baud_pkg::*;
#(
  parameter int unsigned DIV_W = 16,
  parameter int unsigned CNT_W = 18
) (
  input logic             clk,
  input logic             rst_ni,
  input logic             any_we,
  input logic [DIV_W-1:0] divisor,
  input rate_sel_e        sel,
  input logic [CNT_W-1:0] period,
  input logic [CNT_W-1:0] cnt,
  input logic             tick
);

  assert_zero_div_silent_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (divisor == '0) |-> !tick);

  assert_write_restarts_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    any_we |=> (cnt == '0));

  assert_x4_every_cycle_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    ((sel == RATE_X4) && ($past(sel) == RATE_X4)) |-> tick);

  assert_tick_gap_R1: assert property (@(posedge clk) disable iff (!rst_ni)
    (tick && (period > CNT_W'(1))) |=> (!tick || (period == CNT_W'(1))));

endmodule

bind uart_baud_gen uart_baud_gen_chk #(
  .DIV_W (DIV_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk     (clk),
  .rst_ni  (rst_n_int),
  .any_we  (reload),
  .divisor (div_q),
  .sel     (sel),
  .period  (period),
  .cnt     (cnt),
  .tick    (tick)
);

// File: tb/uart_baud_gen_tb.sv
module uart_baud_gen_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;

  typedef struct packed {
    logic        hs;
    logic [15:0] div;
    logic [31:0] per;
  } vec_t;

  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 16'd1,     32'd4},
    '{1'b0, 16'd12,    32'd48},
    '{1'b0, 16'd96,    32'd384},
    '{1'b0, 16'd857,   32'd3428},
    '{1'b0, 16'd1047,  32'd4188},
    '{1'b0, 16'd2304,  32'd9216},
    '{1'b1, 16'h8002,  32'd2},
    '{1'b1, 16'h8001,  32'd1},
    '{1'b1, 16'd12,    32'd48},
    '{1'b1, 16'd1,     32'd4}
  };

  logic       clk;
  logic       rst_n;
  logic [1:0] div_byte_we;
  logic [7:0] wr_byte;
  logic       hs_mode;
  logic       tick;

  int checks;
  int errors;

  uart_baud_gen u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .div_byte_we (div_byte_we),
    .wr_byte     (wr_byte),
    .hs_mode     (hs_mode),
    .tick        (tick)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic put_byte(input int idx, input logic [7:0] b);
    div_byte_we      = '0;
    div_byte_we[idx] = 1'b1;
    wr_byte          = b;
    @(posedge clk);
    @(negedge clk);
    div_byte_we      = '0;
  endtask

  task automatic write_div(input logic [15:0] d);
    put_byte(0, d[7:0]);
    put_byte(1, d[15:8]);
  endtask

  task automatic set_hs(input logic v);
    hs_mode = v;
    @(posedge clk);
    @(negedge clk);
  endtask

  // cycles from now until tick is seen (0 if already high)
  task automatic wait_tick(input int limit, output int n);
    n = 0;
    while (!tick && n < limit) begin
      @(negedge clk);
      n++;
    end
  endtask

  // step one cycle, then count cycles until the next tick
  task automatic next_gap(input int limit, output int n);
    @(negedge clk);
    n = 1;
    while (!tick && n < limit) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic count_ticks(input int cycles, output int c);
    c = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (tick) c++;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    int c;
    string tag;
    checks      = 0;
    errors      = 0;
    rst_n       = 1'b0;
    div_byte_we = '0;
    wr_byte     = '0;
    hs_mode     = 1'b0;

    // R9: tick low in and right after reset, divisor reset to zero (R4)
    repeat (3) @(negedge clk);
    check("R9 tick in reset", int'(tick), 0);
    rst_n = 1'b1;
    count_ticks(60, c);
    check("R9 no tick after reset", c, 0);

    // vector table: period and first-tick position after restart
    for (int v = 0; v < NVEC; v++) begin
      if (VEC[v].hs && VEC[v].div == 16'h8002)      tag = "R5";
      else if (VEC[v].hs && VEC[v].div == 16'h8001) tag = "R6";
      else if (VEC[v].hs)                           tag = "R8";
      else                                          tag = "R1";
      set_hs(VEC[v].hs);
      write_div(VEC[v].div);
      wait_tick(int'(VEC[v].per) + 10, n);
      check({tag, " R3 first tick"}, n, int'(VEC[v].per) - 1);
      next_gap(int'(VEC[v].per) + 10, n);
      check({tag, " period"}, n, int'(VEC[v].per));
    end

    // R2: high byte write keeps low byte: 0x010C -> 1072, then 0x0100 -> 1024
    set_hs(1'b0);
    write_div(16'd12);
    put_byte(1, 8'h01);
    wait_tick(1200, n);
    check("R2 hi write period", n, 1071);
    put_byte(0, 8'h00);
    wait_tick(1200, n);
    check("R2 lo write period", n, 1023);

    // R3: mid-count rewrite restarts the count
    write_div(16'd12);
    wait_tick(60, n);
    repeat (10) @(negedge clk);
    put_byte(0, 8'd12);
    wait_tick(60, n);
    check("R3 restart mid count", n, 47);

    // R8: toggling hs under a normal divisor keeps phase
    wait_tick(60, n);
    repeat (5) @(negedge clk);
    set_hs(1'b1);
    repeat (3) @(negedge clk);
    set_hs(1'b0);
    n = 10;
    while (!tick && n < 100) begin
      @(negedge clk);
      n++;
    end
    check("R8 phase across hs toggle", n, 48);

    // R7: special codes with hs clear are slow divisors
    write_div(16'h8001);
    count_ticks(1000, c);
    check("R7 0x8001 hs clear", c, 0);
    write_div(16'h8002);
    count_ticks(1000, c);
    check("R7 0x8002 hs clear", c, 0);

    // R5: turning hs on over a running long count switches to 2-cycle ticks
    set_hs(1'b1);
    wait_tick(10, n);
    next_gap(10, n);
    check("R5 hs switch on period", n, 2);

    // R4: clearing divisor stops ticks
    write_div(16'd0);
    count_ticks(300, c);
    check("R4 zero divisor", c, 0);

    // R9: reset mid-run clears divisor
    set_hs(1'b0);
    write_div(16'd1);
    rst_n = 1'b0;
    #1;
    check("R9 tick in mid-run reset", int'(tick), 0);
    @(negedge clk);
    rst_n = 1'b1;
    count_ticks(100, c);
    check("R9 no tick after mid-run reset", c, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule